// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port with Configuration Freeze

This block is the register side of one 16-pin general-purpose I/O port. A simple synchronous register bus writes the per-pin configuration: direction mode, push-pull or open-drain output stage, speed code, pull code and a 4-bit alternate-function selector. The same bus writes and reads the output data word and reads the synchronized pad inputs. The block drives a pad model with output-enable, output value, open-drain flag, alternate-function enable and selector per pin. The speed and pull codes are only stored and exported.

Two features go beyond plain storage. The output word can be changed atomically. One write can set some bits and clear others, and a second register only clears bits. Both avoid a read-modify-write. A per-pin configuration freeze is armed by a key protocol of three writes and one read. Once armed, it holds until reset. After that, configuration writes leave the frozen pins' fields alone and still update every other pin.

Bus timing: a write (`bus_en`=1, `bus_we`=1) takes effect at the rising edge. Read data is combinational while `bus_en`=1 and `bus_we`=0. Register word addresses are 0 mode, 1 output type, 2 speed, 3 pull, 4 input, 5 output data, 6 set/clear, 7 freeze, 8 selector for pins 0-7, 9 selector for pins 8-15, and 10 clear-only. Any other address reads 0.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0. All pins are inputs with no drive (`pad_oe`=0, `pad_out`=0, `pad_af_en`=0), and the freeze word at address 7 reads 0.
- R2: Word 0 holds pin i's mode in bits [2i+1:2i]: 00 input, 01 output, 10 alternate function, 11 analog. `pad_oe[i]` can be 1 only in modes 01 and 10, and `pad_out[i]` is 0 in modes 00 and 11.
- R3: Word 1 bit i selects open-drain (1) or push-pull (0), and is mirrored on `pad_od[i]`. In a driving mode, `pad_out[i]` equals the pin's data value. An open-drain pin asserts `pad_oe[i]` only while that value is 0.
- R4: Pin n's 4-bit selector sits in word 8+(n>>3) at bits [(n&7)*4+3:(n&7)*4] and appears on `pad_af_sel[4n+3:4n]`. In mode 10, the data value is `alt_dout[n]` and `pad_af_en[n]`=1.
- R5: A write to word 5 loads bits [15:0] into the output data, which reads back in bits [15:0]. In mode 01, it is the pin data value.
- R6: A write to word 6 sets the output bits given in [15:0] and clears those given in [31:16]. Where a pin has both bits, the set wins. Word 6 reads 0.
- R7: A write to word 10 clears the output bits given in [15:0] and ignores [31:16]. Word 10 reads 0.
- R8: Word 4 bits [15:0] return `pad_in` through two flops. A change made before one rising edge is not yet visible, and it is visible after the second edge. Writes to word 4 have no effect.
- R9: Words 2 and 3 store two bits per pin, read back, and appear unchanged on `cfg_speed` and `cfg_pull`.
- R10: The freeze completes when word 7 is written with bit 16=1 and pin mask P, then bit 16=0 with P, then bit 16=1 with P, and then word 7 is read. That completing read still returns the old value. Later reads return bit 16=1 and P in bits [15:0].
- R11: Once frozen, writes to words 0, 1, 2, 3, 8 and 9 leave the fields of frozen pins unchanged and update the fields of the other pins. Output data writes are not affected.
- R12: Any break in the freeze protocol freezes nothing. A break is a changed pin mask or a key bit out of order. A write with bit 16=1 during a break starts a new attempt.
- R13: After the key bit reads 1, further writes to word 7, including complete protocols, leave the freeze word unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 16 | Raw pad input levels |
| alt_dout | input | 16 | Per-pin data from the selected alternate function |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| pad_od | output | 16 | Open-drain flag per pin |
| pad_af_en | output | 16 | Pin is in alternate-function mode |
| pad_af_sel | output | 64 | 4-bit alternate-function selector per pin |
| cfg_speed | output | 32 | Stored speed codes, 2 bits per pin |
| cfg_pull | output | 32 | Stored pull codes, 2 bits per pin |

## Verification
Random writes with random data across all configuration and output words are applied first with nothing frozen. After each write the word is read back and every pad output is compared with the value predicted from the register fields and `alt_dout`. This separates field placement, mode decoding and open-drain gating. The same random traffic is repeated after a partial freeze of pins 0-3 and 8-11. This tells per-pin masking apart from all-or-nothing masking, and shows whether the mask is placed correctly in 1-, 2- and 4-bit fields. Directed cases cover set-and-clear on the same pin, the clear-only upper half, the two-edge input latency and protocols with a wrong mask, a repeated key and a completed freeze.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PINS       = 16;
    localparam int DW         = 32;
    localparam int AW         = 4;
    localparam int MODE_W     = 2;
    localparam int AF_W       = 4;
    localparam int AF_PER_REG = DW / AF_W;
    localparam int AF_REGS    = PINS / AF_PER_REG;
    localparam int KEY_BIT    = PINS;

    typedef enum logic [1:0] {
        PM_IN  = 2'd0,
        PM_OUT = 2'd1,
        PM_ALT = 2'd2,
        PM_ANA = 2'd3
    } pin_mode_e;

    typedef enum logic [AW-1:0] {
        A_MODE   = 4'd0,
        A_OTYPE  = 4'd1,
        A_SPEED  = 4'd2,
        A_PULL   = 4'd3,
        A_IN     = 4'd4,
        A_OUT    = 4'd5,
        A_SETCLR = 4'd6,
        A_LOCK   = 4'd7,
        A_AFLO   = 4'd8,
        A_AFHI   = 4'd9,
        A_CLR    = 4'd10
    } reg_addr_e;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_ONE,
        LK_ZERO,
        LK_ARMED
    } lock_st_e;

    typedef struct packed {
        logic          en;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    // widen a per-pin mask to a 2-bit-per-pin field mask
    function automatic logic [DW-1:0] spread2(input logic [PINS-1:0] m);
        logic [DW-1:0] r;
        r = '0;
        for (int i = 0; i < PINS; i++) r[MODE_W*i +: MODE_W] = {MODE_W{m[i]}};
        return r;
    endfunction

    // widen a mask of one selector word's pins to 4 bits per pin
    function automatic logic [DW-1:0] spread4(input logic [AF_PER_REG-1:0] m);
        logic [DW-1:0] r;
        r = '0;
        for (int i = 0; i < AF_PER_REG; i++) r[AF_W*i +: AF_W] = {AF_W{m[i]}};
        return r;
    endfunction

    function automatic logic [DW-1:0] keep_merge(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v,
                                                 input logic [DW-1:0] keep);
        return (old_v & keep) | (new_v & ~keep);
    endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_mode,
    input  logic                  wr_otype,
    input  logic                  wr_speed,
    input  logic                  wr_pull,
    input  logic [AF_REGS-1:0]    wr_af,
    input  logic [DW-1:0]         wdata,
    input  logic [PINS-1:0]       lock_mask,
    output logic [DW-1:0]         mode_q,
    output logic [PINS-1:0]       otype_q,
    output logic [DW-1:0]         speed_q,
    output logic [DW-1:0]         pull_q,
    output logic [AF_REGS*DW-1:0] af_q
);
    logic [DW-1:0] keep2;
    assign keep2 = spread2(lock_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            otype_q <= '0;
            speed_q <= '0;
            pull_q  <= '0;
        end else begin
            if (wr_mode)  mode_q  <= keep_merge(mode_q, wdata, keep2);
            if (wr_speed) speed_q <= keep_merge(speed_q, wdata, keep2);
            if (wr_pull)  pull_q  <= keep_merge(pull_q, wdata, keep2);
            if (wr_otype) otype_q <= (otype_q & lock_mask) | (wdata[PINS-1:0] & ~lock_mask);
        end
    end

    for (genvar g = 0; g < AF_REGS; g++) begin : g_af
        logic [DW-1:0] af_r;
        logic [DW-1:0] keep4;
        assign keep4 = spread4(lock_mask[g*AF_PER_REG +: AF_PER_REG]);
        always_ff @(posedge clk) begin
            if (rst)          af_r <= '0;
            else if (wr_af[g]) af_r <= keep_merge(af_r, wdata, keep4);
        end
        assign af_q[g*DW +: DW] = af_r;
    end
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_wr,
    input  logic              lk_rd,
    input  logic [KEY_BIT:0]  lk_data,
    output logic [PINS-1:0]   lock_q,
    output logic              key_q
);
    lock_st_e        st_q, st_d;
    logic [PINS-1:0] pend_q;
    logic            key_in, same;

    assign key_in = lk_data[KEY_BIT];
    assign same   = (lk_data[PINS-1:0] == pend_q);

    // any break restarts: a key=1 write opens a new attempt
    always_comb begin
        st_d = key_in ? LK_ONE : LK_IDLE;
        case (st_q)
            LK_ONE:  if (!key_in && same) st_d = LK_ZERO;
            LK_ZERO: if (key_in && same)  st_d = LK_ARMED;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LK_IDLE;
            pend_q <= '0;
            lock_q <= '0;
            key_q  <= 1'b0;
        end else if (!key_q) begin
            if (lk_wr) begin
                st_q   <= st_d;
                pend_q <= lk_data[PINS-1:0];
            end else if (lk_rd && st_q == LK_ARMED) begin
                key_q  <= 1'b1;
                lock_q <= pend_q;
                st_q   <= LK_IDLE;
            end
        end
    end
endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_full,
    input  logic            wr_setclr,
    input  logic            wr_clr,
    input  logic [DW-1:0]   wdata,
    output logic [PINS-1:0] out_q
);
    always_ff @(posedge clk) begin
        if (rst)            out_q <= '0;
        else if (wr_full)   out_q <= wdata[PINS-1:0];
        else if (wr_setclr) out_q <= (out_q & ~wdata[2*PINS-1:PINS]) | wdata[PINS-1:0];
        else if (wr_clr)    out_q <= out_q & ~wdata[PINS-1:0];
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_pkg::*;
(
    input  logic [DW-1:0]   mode_q,
    input  logic [PINS-1:0] otype_q,
    input  logic [PINS-1:0] out_q,
    input  logic [PINS-1:0] alt_dout,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_af_en
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pin_mode_e m;
        logic      drv, val;
        assign m            = pin_mode_e'(mode_q[MODE_W*p +: MODE_W]);
        assign drv          = (m == PM_OUT) || (m == PM_ALT);
        assign val          = (m == PM_ALT) ? alt_dout[p] : out_q[p];
        assign pad_oe[p]    = drv && (!otype_q[p] || !val);
        assign pad_out[p]   = drv && val;
        assign pad_af_en[p] = (m == PM_ALT);
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic [PINS-1:0]       pad_in,
    input  logic [PINS-1:0]       alt_dout,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe,
    output logic [PINS-1:0]       pad_od,
    output logic [PINS-1:0]       pad_af_en,
    output logic [AF_REGS*DW-1:0] pad_af_sel,
    output logic [DW-1:0]         cfg_speed,
    output logic [DW-1:0]         cfg_pull
);
    bus_req_t req;
    logic     wr_go, rd_go;
    logic [AF_REGS-1:0] wr_af;

    logic [DW-1:0]         mode_q, speed_q, pull_q;
    logic [PINS-1:0]       otype_q, out_q, in_q, lock_q;
    logic                  key_q;
    logic [AF_REGS*DW-1:0] af_q;

    assign req   = '{en: bus_en, we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign wr_go = req.en && req.we;
    assign rd_go = req.en && !req.we;

    for (genvar g = 0; g < AF_REGS; g++) begin : g_afdec
        assign wr_af[g] = wr_go && (req.addr == AW'(A_AFLO) + AW'(g));
    end

    gpio_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_mode   (wr_go && req.addr == A_MODE),
        .wr_otype  (wr_go && req.addr == A_OTYPE),
        .wr_speed  (wr_go && req.addr == A_SPEED),
        .wr_pull   (wr_go && req.addr == A_PULL),
        .wr_af     (wr_af),
        .wdata     (req.wdata),
        .lock_mask (lock_q),
        .mode_q    (mode_q),
        .otype_q   (otype_q),
        .speed_q   (speed_q),
        .pull_q    (pull_q),
        .af_q      (af_q)
    );

    gpio_lock_ctrl u_lock (
        .clk     (clk),
        .rst     (rst),
        .lk_wr   (wr_go && req.addr == A_LOCK),
        .lk_rd   (rd_go && req.addr == A_LOCK),
        .lk_data (req.wdata[KEY_BIT:0]),
        .lock_q  (lock_q),
        .key_q   (key_q)
    );

    gpio_out_data u_out (
        .clk       (clk),
        .rst       (rst),
        .wr_full   (wr_go && req.addr == A_OUT),
        .wr_setclr (wr_go && req.addr == A_SETCLR),
        .wr_clr    (wr_go && req.addr == A_CLR),
        .wdata     (req.wdata),
        .out_q     (out_q)
    );

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (in_q)
    );

    gpio_pad_drive u_pad (
        .mode_q    (mode_q),
        .otype_q   (otype_q),
        .out_q     (out_q),
        .alt_dout  (alt_dout),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_af_en (pad_af_en)
    );

    assign pad_od     = otype_q;
    assign pad_af_sel = af_q;
    assign cfg_speed  = speed_q;
    assign cfg_pull   = pull_q;

    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            case (reg_addr_e'(req.addr))
                A_MODE:  bus_rdata = mode_q;
                A_OTYPE: bus_rdata[PINS-1:0] = otype_q;
                A_SPEED: bus_rdata = speed_q;
                A_PULL:  bus_rdata = pull_q;
                A_IN:    bus_rdata[PINS-1:0] = in_q;
                A_OUT:   bus_rdata[PINS-1:0] = out_q;
                A_LOCK: begin
                    bus_rdata[PINS-1:0] = lock_q;
                    bus_rdata[KEY_BIT]  = key_q;
                end
                A_AFLO:  bus_rdata = af_q[DW-1:0];
                A_AFHI:  bus_rdata = af_q[2*DW-1:DW];
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            bus_en,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   mode_q,
    input logic [PINS-1:0] lock_q,
    input logic            key_q,
    input logic [PINS-1:0] out_q,
    input logic [PINS-1:0] pad_oe,
    input logic [PINS-1:0] pad_od,
    input logic [PINS-1:0] pad_out
);
    logic [PINS-1:0] drv_mask;
    always_comb begin
        for (int i = 0; i < PINS; i++)
            drv_mask[i] = (mode_q[2*i +: 2] == PM_OUT) || (mode_q[2*i +: 2] == PM_ALT);
    end

    AST_NO_IDLE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~drv_mask) == '0); // R2

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_od & pad_out) == '0); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == A_SETCLR)
        |=> ((out_q & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0]))); // R6

    AST_CLR_DONE: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == A_CLR)
        |=> ((out_q & $past(bus_wdata[PINS-1:0])) == '0)); // R7

    AST_LOCKED_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        key_q |=> (((mode_q ^ $past(mode_q)) & spread2(lock_q)) == '0)); // R11

    AST_KEY_STICKY: assert property (@(posedge clk) disable iff (rst)
        key_q |=> key_q); // R13

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        key_q |=> $stable(lock_q)); // R13
endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mode_q    (mode_q),
    .lock_q    (lock_q),
    .key_q     (key_q),
    .out_q     (out_q),
    .pad_oe    (pad_oe),
    .pad_od    (pad_od),
    .pad_out   (pad_out)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_en = 0, bus_we = 0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0, alt_dout = '0;
    logic [15:0] pad_out, pad_oe, pad_od, pad_af_en;
    logic [63:0] pad_af_sel;
    logic [31:0] cfg_speed, cfg_pull;

    gpio_port dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .alt_dout(alt_dout),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_af_en(pad_af_en),
        .pad_af_sel(pad_af_sel), .cfg_speed(cfg_speed), .cfg_pull(cfg_pull)
    );

    always #2 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_mode = 0, m_speed = 0, m_pull = 0;
    logic [15:0] m_ot = 0, m_out = 0, m_lock = 0, m_in = 0;
    logic [31:0] m_af [2] = '{32'h0, 32'h0};
    logic        m_key = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    // bit b of a field of width w belongs to pin first+b/w
    function automatic logic [31:0] keep_mask(input int w, input logic [15:0] lk, input int first);
        logic [31:0] k;
        for (int b = 0; b < 32; b++) k[b] = ((first + b / w) < 16) ? lk[first + b / w] : 1'b0;
        return k;
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] k;
        case (a)
            0: begin k = keep_mask(2, m_lock, 0); m_mode = (m_mode & k) | (d & ~k); end
            1: begin k = keep_mask(1, m_lock, 0); m_ot = (m_ot & k[15:0]) | (d[15:0] & ~k[15:0]); end
            2: begin k = keep_mask(2, m_lock, 0); m_speed = (m_speed & k) | (d & ~k); end
            3: begin k = keep_mask(2, m_lock, 0); m_pull = (m_pull & k) | (d & ~k); end
            5: m_out = d[15:0];
            6: for (int i = 0; i < 16; i++) begin
                   if (d[i]) m_out[i] = 1'b1;
                   else if (d[16+i]) m_out[i] = 1'b0;
               end
            8: begin k = keep_mask(4, m_lock, 0); m_af[0] = (m_af[0] & k) | (d & ~k); end
            9: begin k = keep_mask(4, m_lock, 8); m_af[1] = (m_af[1] & k) | (d & ~k); end
            10: m_out = m_out & ~d[15:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            0: return m_mode;
            1: return {16'h0, m_ot};
            2: return m_speed;
            3: return m_pull;
            4: return {16'h0, m_in};
            5: return {16'h0, m_out};
            7: return {15'h0, m_key, m_lock};
            8: return m_af[0];
            9: return m_af[1];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check_pads(input string ctx);
        logic [15:0] e_oe, e_out, e_af;
        logic [63:0] e_sel;
        for (int p = 0; p < 16; p++) begin
            logic [1:0] m;
            logic drv, v;
            m = m_mode[2*p +: 2];
            drv = (m == 2'b01) || (m == 2'b10);
            v = (m == 2'b10) ? alt_dout[p] : m_out[p];
            e_oe[p] = drv && (!m_ot[p] || !v);
            e_out[p] = drv && v;
            e_af[p] = (m == 2'b10);
            e_sel[4*p +: 4] = m_af[p/8][4*(p%8) +: 4];
        end
        chk({"R2 pad_oe ", ctx}, {48'h0, pad_oe}, {48'h0, e_oe});
        chk({"R3 pad_out ", ctx}, {48'h0, pad_out}, {48'h0, e_out});
        chk({"R3 pad_od ", ctx}, {48'h0, pad_od}, {48'h0, m_ot});
        chk({"R4 pad_af_en ", ctx}, {48'h0, pad_af_en}, {48'h0, e_af});
        chk({"R4 pad_af_sel ", ctx}, pad_af_sel, e_sel);
        chk({"R9 cfg_speed ", ctx}, {32'h0, cfg_speed}, {32'h0, m_speed});
        chk({"R9 cfg_pull ", ctx}, {32'h0, cfg_pull}, {32'h0, m_pull});
    endtask

    function automatic logic [3:0] pick_addr(input int unsigned s);
        case (s)
            0: return 4'd0; 1: return 4'd1; 2: return 4'd2; 3: return 4'd3;
            4: return 4'd5; 5: return 4'd6; 6: return 4'd8; 7: return 4'd9;
            default: return 4'd10;
        endcase
    endfunction

    task automatic random_phase(input int n, input string ctx);
        logic [31:0] got;
        for (int it = 0; it < n; it++) begin
            logic [3:0] a;
            logic [31:0] d;
            a = pick_addr($urandom_range(0, 8));
            d = $urandom;
            alt_dout = 16'($urandom);
            wr(a, d);
            model_write(a, d);
            rd(a, got);
            chk({"R5 R6 R7 R11 readback ", ctx}, {32'h0, got}, {32'h0, model_read(a)});
            check_pads(ctx);
        end
    endtask

    task automatic lock_word(input logic key, input logic [15:0] pins);
        wr(4'd7, {15'h0, key, pins});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), got);
            chk("R1 reset readback", {32'h0, got}, 64'h0);
        end
        chk("R1 reset pad_oe", {48'h0, pad_oe}, 64'h0);
        chk("R1 reset pad_af_en", {48'h0, pad_af_en}, 64'h0);
        check_pads("R1 reset");

        // random phase, nothing frozen
        random_phase(200, "open");

        // R6 set wins over clear on the same pin
        wr(4'd5, 32'h0000_0002); model_write(5, 32'h2);
        wr(4'd6, 32'h0003_0001); model_write(6, 32'h0003_0001);
        rd(4'd5, got);
        chk("R6 set priority", {32'h0, got}, 64'h1);
        rd(4'd6, got);
        chk("R6 reads zero", {32'h0, got}, 64'h0);

        // R7 clear-only ignores the upper half
        wr(4'd5, 32'h0000_FFFF); model_write(5, 32'hFFFF);
        wr(4'd10, 32'hFFFF_00F0); model_write(10, 32'hFFFF_00F0);
        rd(4'd5, got);
        chk("R7 clear only", {32'h0, got}, 64'hFF0F);

        // R3 open-drain on pin 0 in output mode
        wr(4'd0, 32'h1); model_write(0, 32'h1);
        wr(4'd1, 32'h1); model_write(1, 32'h1);
        wr(4'd5, 32'h1); model_write(5, 32'h1);
        chk("R3 od high oe", {63'h0, pad_oe[0]}, 64'h0);
        chk("R3 od high out", {63'h0, pad_out[0]}, 64'h1);
        wr(4'd5, 32'h0); model_write(5, 32'h0);
        chk("R3 od low oe", {63'h0, pad_oe[0]}, 64'h1);
        chk("R3 od low out", {63'h0, pad_out[0]}, 64'h0);

        // R4 pin 9 alternate function with selector 0xA
        wr(4'd1, 32'h0); model_write(1, 32'h0);
        wr(4'd0, 32'h2 << 18); model_write(0, 32'h2 << 18);
        wr(4'd9, 32'h0000_00A0); model_write(9, 32'h0000_00A0);
        alt_dout = 16'h0200;
        #1;
        chk("R4 pin9 sel", {60'h0, pad_af_sel[39:36]}, 64'hA);
        chk("R4 pin9 af_en", {63'h0, pad_af_en[9]}, 64'h1);
        chk("R4 pin9 drives alt", {62'h0, pad_oe[9], pad_out[9]}, 64'h3);
        check_pads("R4 directed");

        // R8 two-flop input path
        pad_in = 16'hA5C3;
        @(posedge clk); @(negedge clk);
        rd(4'd4, got);
        chk("R8 one edge old", {32'h0, got}, 64'h0);
        rd(4'd4, got);
        chk("R8 two edges new", {32'h0, got}, 64'hA5C3);
        m_in = 16'hA5C3;
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, got);
        chk("R8 write ignored", {32'h0, got}, 64'hA5C3);

        // R12 changed mask breaks the protocol
        lock_word(1, 16'h00F0); lock_word(0, 16'h00F1); lock_word(1, 16'h00F0);
        rd(4'd7, got);
        rd(4'd7, got);
        chk("R12 wrong mask nothing frozen", {32'h0, got}, 64'h0);
        wr(4'd0, 32'hFFFF_FFFF); model_write(0, 32'hFFFF_FFFF);
        rd(4'd0, got);
        chk("R12 mode still writable", {32'h0, got}, 64'hFFFF_FFFF);
        wr(4'd0, 32'h0); model_write(0, 32'h0);

        // R12 key order broken: zero first, then completion without restart
        lock_word(0, 16'h0F0F); lock_word(1, 16'h0F0F); lock_word(1, 16'h0F0F);
        rd(4'd7, got);
        rd(4'd7, got);
        chk("R12 wrong order nothing frozen", {32'h0, got}, 64'h0);

        // R10 with R12 restart: repeated key=1 opens a new attempt
        lock_word(1, 16'hFFFF); lock_word(1, 16'h0F0F);
        lock_word(0, 16'h0F0F); lock_word(1, 16'h0F0F);
        rd(4'd7, got);
        chk("R10 completing read old value", {32'h0, got}, 64'h0);
        rd(4'd7, got);
        chk("R10 frozen word", {32'h0, got}, 64'h1_0F0F);
        m_lock = 16'h0F0F; m_key = 1;

        // R13 further protocols have no effect
        lock_word(1, 16'hFFFF); lock_word(0, 16'hFFFF); lock_word(1, 16'hFFFF);
        rd(4'd7, got);
        rd(4'd7, got);
        chk("R13 freeze word unchanged", {32'h0, got}, 64'h1_0F0F);

        // R11 directed: all-ones mode write touches only unfrozen pins
        wr(4'd0, 32'hFFFF_FFFF); model_write(0, 32'hFFFF_FFFF);
        rd(4'd0, got);
        chk("R11 mode partial", {32'h0, got}, {32'h0, m_mode});
        chk("R11 mode literal", {32'h0, got}, 64'hFF00_FF00);
        wr(4'd5, 32'h0000_FFFF); model_write(5, 32'hFFFF);
        rd(4'd5, got);
        chk("R11 output data not frozen", {32'h0, got}, 64'hFFFF);

        random_phase(200, "frozen");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule